// File: doc/BRIEF.md
# Speed-Change Stall Recovery Monitor

This block supervises a serial link after its training state machine has been switched on. It samples the training-state code and the link flags at a fixed interval. It decides at each sample whether the link has come up, whether the link is stuck in the receiver-lock phase of recovery with no valid receive data, or whether it should simply keep waiting.

When it sees the stuck pattern, the block raises two PHY receiver override enables together for a fixed time. One forces receive data on and the other forces the receive PLL on. It then drops both, which kicks the receiver out of the stall. The block counts how many samples it has taken. It reports a link failure when a fixed budget of samples passes without link-up, and it reports success as soon as link-up is seen.

Timing is given in microseconds and converted to clock cycles from a clock-frequency parameter. A start pulse arms the monitor and re-arms it at any later time. The result flags hold until the next start pulse.

Top module: `link_stall_mon`

## Requirements
- R1: After reset, all four outputs are 0 and the monitor stays idle, taking no samples, until `start` is seen high.
- R2: `start` high at a clock edge clears `link_ok`, `link_fail` and both overrides at that edge, zeroes the sample count, and restarts the sample interval, including when a pulse is in progress.
- R3: A sample is taken every POLL_CYC = CLK_KHZ*POLL_US/1000 cycles. The first sample falls at the POLL_CYC-th rising edge after the edge that registered `start`.
- R4: The link counts as established at a sample when `link_up`=1 and `in_training`=0. `link_ok` then goes to 1 at that sample edge.
- R5: A stall is declared at a sample when `ltssm_state` equals 6'h0D (receiver-lock in recovery), `rx_valid`=0, and the link is not established. Every other state code, or `rx_valid`=1, leaves both overrides at 0.
- R6: On a stall, `ovrd_rx_data_en` and `ovrd_rx_pll_en` rise together at the sample edge. They stay 1 for exactly PULSE_CYC = CLK_KHZ*PULSE_US/1000 cycles and then both return to 0.
- R7: No sample is taken while a pulse is active. The next sample falls POLL_CYC cycles after the pulse ends, and the sample count carries across the pulse.
- R8: Every sample that does not find the link established counts, stalled ones included. When the count reaches MAX_POLLS, `link_fail` goes to 1: at that sample edge if it did not stall, or at the end of its pulse if it did.
- R9: `link_ok` and `link_fail` are never both 1. Once set, either one holds until the next `start`, whatever the inputs do. While either is 1, both overrides stay 0.
- R10: When a sample finds the link established and the stall pattern present at the same time, link-up wins: `link_ok` is set and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arm or re-arm the monitor |
| ltssm_state | input | 6 | Current training-state code |
| link_up | input | 1 | Link-up flag from the link layer |
| in_training | input | 1 | Link training in progress flag |
| rx_valid | input | 1 | PHY receive-valid status bit |
| ovrd_rx_data_en | output | 1 | Receive-data enable override |
| ovrd_rx_pll_en | output | 1 | Receive-PLL enable override |
| link_ok | output | 1 | Link established (held) |
| link_fail | output | 1 | Sample budget used up without link (held) |

## Verification
The checker's pulse-trigger property assumes that the training-state and receive-valid inputs seen at a sample edge are the values that decided it. The bench therefore changes inputs only a short time after a rising edge and never in the sample cycle itself. The pulse-length property counts a full PULSE_CYC run only when no `start` cut the pulse short, so the one case that aborts a pulse on purpose is kept separate from the length checks. A small configuration, with 10-cycle samples, 50-cycle pulses and a budget of 16, lets the bench sweep every 6-bit state code. It also lets the bench time the failure exactly under a persistent stall and under a plain no-link condition.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_POLL  = 2'd1,
        MON_PULSE = 2'd2,
        MON_DONE  = 2'd3
    } mon_state_e;

    // Converts a time in microseconds to a cycle count, minimum one cycle.
    function automatic int us_to_cycles(input int khz, input int us);
        longint c;
        c = (longint'(khz) * longint'(us)) / 1000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/lsm_interval.sv
module lsm_interval #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = hit ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lsm_classify.sv
module lsm_classify #(
    parameter logic [5:0] STALL_CODE = 6'h0D
) (
    input  logic [5:0] ltssm_state,
    input  logic       link_up,
    input  logic       in_training,
    input  logic       rx_valid,
    output logic       linked,
    output logic       stalled
);
    always_comb begin
        linked  = link_up && !in_training;
        stalled = !linked && (ltssm_state == STALL_CODE) && !rx_valid;
    end
endmodule

// File: rtl/link_stall_mon.sv
module link_stall_mon #(
    parameter int CLK_KHZ   = 50000,
    parameter int POLL_US   = 10,
    parameter int PULSE_US  = 3000,
    parameter int MAX_POLLS = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [5:0] ltssm_state,
    input  logic       link_up,
    input  logic       in_training,
    input  logic       rx_valid,
    output logic       ovrd_rx_data_en,
    output logic       ovrd_rx_pll_en,
    output logic       link_ok,
    output logic       link_fail
);
    import lsm_pkg::*;

    localparam int POLL_CYC  = us_to_cycles(CLK_KHZ, POLL_US);
    localparam int PULSE_CYC = us_to_cycles(CLK_KHZ, PULSE_US);
    localparam int CNT_W     = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0] BUDGET = CNT_W'(MAX_POLLS);

    typedef struct packed {
        mon_state_e       st;
        logic [CNT_W-1:0] polls;
        logic             ok;
        logic             fail;
    } mon_regs_t;

    mon_regs_t r_d, r_q;

    logic linked, stalled;
    logic poll_hit, pulse_hit;
    logic [CNT_W-1:0] polls_inc;

    lsm_classify u_class (
        .ltssm_state (ltssm_state),
        .link_up     (link_up),
        .in_training (in_training),
        .rx_valid    (rx_valid),
        .linked      (linked),
        .stalled     (stalled)
    );

    lsm_interval #(.LIMIT(POLL_CYC)) u_poll_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start || (r_q.st != MON_POLL)),
        .en    (!start && (r_q.st == MON_POLL)),
        .hit   (poll_hit)
    );

    lsm_interval #(.LIMIT(PULSE_CYC)) u_pulse_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start || (r_q.st != MON_PULSE)),
        .en    (!start && (r_q.st == MON_PULSE)),
        .hit   (pulse_hit)
    );

    always_comb begin
        r_d       = r_q;
        polls_inc = r_q.polls + CNT_W'(1);
        if (start) begin
            r_d.st    = MON_POLL;
            r_d.polls = '0;
            r_d.ok    = 1'b0;
            r_d.fail  = 1'b0;
        end else begin
            unique case (r_q.st)
                MON_POLL: begin
                    if (poll_hit) begin
                        if (linked) begin
                            r_d.ok = 1'b1;
                            r_d.st = MON_DONE;
                        end else begin
                            r_d.polls = polls_inc;
                            if (stalled) begin
                                r_d.st = MON_PULSE;
                            end else if (polls_inc >= BUDGET) begin
                                r_d.fail = 1'b1;
                                r_d.st   = MON_DONE;
                            end
                        end
                    end
                end
                MON_PULSE: begin
                    if (pulse_hit) begin
                        if (r_q.polls >= BUDGET) begin
                            r_d.fail = 1'b1;
                            r_d.st   = MON_DONE;
                        end else begin
                            r_d.st = MON_POLL;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= MON_IDLE;
            r_q.polls <= '0;
            r_q.ok    <= 1'b0;
            r_q.fail  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ovrd_rx_data_en = (r_q.st == MON_PULSE);
    assign ovrd_rx_pll_en  = (r_q.st == MON_PULSE);
    assign link_ok         = r_q.ok;
    assign link_fail       = r_q.fail;
endmodule

// File: rtl/link_stall_mon_chk.sv
module link_stall_mon_chk #(
    parameter int CLK_KHZ  = 50000,
    parameter int PULSE_US = 3000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [5:0] ltssm_state,
    input logic       rx_valid,
    input logic       ovrd_rx_data_en,
    input logic       ovrd_rx_pll_en,
    input logic       link_ok,
    input logic       link_fail
);
    localparam int PULSE_CYC = lsm_pkg::us_to_cycles(CLK_KHZ, PULSE_US);

    int run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               run_q <= 0;
        else if (ovrd_rx_data_en) run_q <= run_q + 1;
        else                      run_q <= 0;
    end

    AST_OVRD_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ovrd_rx_data_en == ovrd_rx_pll_en);                                   // R6
    AST_PULSE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovrd_rx_data_en) |-> ($past(ltssm_state) == 6'h0D) && !$past(rx_valid)); // R5
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ovrd_rx_data_en |-> run_q < PULSE_CYC);                               // R6
    AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovrd_rx_data_en) && !$past(start) |-> $past(run_q) == PULSE_CYC - 1); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_ok && link_fail));                                             // R9
    AST_OK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok && !start |=> link_ok);                                       // R9
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail && !start |=> link_fail);                                   // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok || link_fail) |-> !ovrd_rx_data_en);                         // R9
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !link_ok && !link_fail && !ovrd_rx_data_en);                // R2
endmodule

bind link_stall_mon link_stall_mon_chk #(.CLK_KHZ(CLK_KHZ), .PULSE_US(PULSE_US)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .ltssm_state     (ltssm_state),
    .rx_valid        (rx_valid),
    .ovrd_rx_data_en (ovrd_rx_data_en),
    .ovrd_rx_pll_en  (ovrd_rx_pll_en),
    .link_ok         (link_ok),
    .link_fail       (link_fail)
);

// File: tb/sim_link_stall_mon.sv
`timescale 1ns/1ps
module sim_link_stall_mon;
    localparam int KHZ = 1000, P_US = 10, U_US = 50, MAXP = 16;
    localparam int POLL = KHZ * P_US / 1000;
    localparam int PUL  = KHZ * U_US / 1000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [5:0] ltssm_state = 6'h00;
    logic link_up = 1'b0, in_training = 1'b0, rx_valid = 1'b0;
    logic ovrd_d, ovrd_p, link_ok, link_fail;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    link_stall_mon #(.CLK_KHZ(KHZ), .POLL_US(P_US), .PULSE_US(U_US), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ltssm_state(ltssm_state),
        .link_up(link_up), .in_training(in_training), .rx_valid(rx_valid),
        .ovrd_rx_data_en(ovrd_d), .ovrd_rx_pll_en(ovrd_p),
        .link_ok(link_ok), .link_fail(link_fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Leaves time just after the edge that registers start (edge 0).
    task automatic arm();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic set_in(input logic [5:0] s, input logic up, input logic tr, input logic rv);
        ltssm_state = s; link_up = up; in_training = tr; rx_valid = rv;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        adv(3);
        rst_n = 1'b1;
        // R1: outputs idle after reset, and no sampling without start
        set_in(6'h0D, 1'b0, 1'b0, 1'b0);
        adv(3 * POLL);
        chk("R1 ovrd idle", int'(ovrd_d | ovrd_p), 0);
        chk("R1 flags idle", int'({link_ok, link_fail}), 0);

        // R3/R4: link up from the start -> ok exactly at the first sample
        set_in(6'h11, 1'b1, 1'b0, 1'b1);
        arm();
        adv(POLL - 1);
        chk("R3 before first sample", int'(link_ok), 0);
        adv(1);
        chk("R4 link_ok at first sample", int'(link_ok), 1);
        chk("R4 no fail", int'(link_fail), 0);
        // R9: ok held after link drops
        set_in(6'h0D, 1'b0, 1'b1, 1'b0);
        adv(5 * POLL);
        chk("R9 ok sticky", int'(link_ok), 1);
        chk("R9 no ovrd when done", int'(ovrd_d), 0);

        // R2: start clears flags
        arm();
        chk("R2 start clears ok", int'(link_ok), 0);

        // R10: link up and stall pattern together -> ok, no pulse
        set_in(6'h0D, 1'b1, 1'b0, 1'b0);
        arm();
        adv(POLL);
        chk("R10 ok wins", int'(link_ok), 1);
        chk("R10 no pulse", int'(ovrd_d), 0);

        // R5: sweep all state codes with rx_valid low
        for (int s = 0; s < 64; s++) begin
            set_in(6'(s), 1'b0, 1'b0, 1'b0);
            arm();
            adv(POLL);
            chk($sformatf("R5 state %0d", s), int'(ovrd_d), (s == 13) ? 1 : 0);
        end
        // R5: rx_valid high suppresses
        set_in(6'h0D, 1'b0, 1'b0, 1'b1);
        arm();
        adv(POLL);
        chk("R5 rx_valid suppresses", int'(ovrd_d), 0);
        // R4: link_up with in_training set is not established
        set_in(6'h11, 1'b1, 1'b1, 1'b1);
        arm();
        adv(POLL);
        chk("R4 in_training blocks ok", int'(link_ok), 0);

        // R8: no link, no stall -> fail exactly after MAXP samples
        set_in(6'h05, 1'b0, 1'b0, 1'b1);
        arm();
        adv(MAXP * POLL - 1);
        chk("R8 no fail before budget", int'(link_fail), 0);
        adv(1);
        chk("R8 fail at budget", int'(link_fail), 1);
        set_in(6'h11, 1'b1, 1'b0, 1'b1);
        adv(3 * POLL);
        chk("R9 fail sticky", int'(link_fail), 1);
        chk("R9 ok stays low after fail", int'(link_ok), 0);

        // R6/R7: pulse length, then resume sampling
        set_in(6'h0D, 1'b0, 1'b0, 1'b0);
        arm();
        adv(POLL - 1);
        chk("R6 ovrd low before sample", int'(ovrd_d), 0);
        adv(1);
        chk("R6 data override up", int'(ovrd_d), 1);
        chk("R6 pll override up", int'(ovrd_p), 1);
        set_in(6'h11, 1'b1, 1'b0, 1'b1);
        adv(PUL - 1);
        chk("R6 override held", int'(ovrd_d & ovrd_p), 1);
        chk("R7 no sample during pulse", int'(link_ok), 0);
        adv(1);
        chk("R6 overrides dropped", int'(ovrd_d | ovrd_p), 0);
        adv(POLL - 1);
        chk("R7 next sample not early", int'(link_ok), 0);
        adv(1);
        chk("R7 sample after pulse", int'(link_ok), 1);

        // R7/R8: persistent stall, count kept across pulses
        set_in(6'h0D, 1'b0, 1'b0, 1'b0);
        arm();
        adv(MAXP * (POLL + PUL) - 1);
        chk("R8 last pulse active", int'(ovrd_d), 1);
        chk("R7 no fail before last pulse ends", int'(link_fail), 0);
        adv(1);
        chk("R8 fail at end of last pulse", int'(link_fail), 1);
        chk("R8 overrides low at fail", int'(ovrd_d), 0);

        // R2: start during a pulse drops overrides and restarts interval
        arm();
        adv(POLL + 5);
        chk("R2 pulse running", int'(ovrd_d), 1);
        arm();
        chk("R2 start aborts pulse", int'(ovrd_d | ovrd_p), 0);
        adv(POLL - 1);
        chk("R2 interval restarted", int'(ovrd_d), 0);
        adv(1);
        chk("R2 new pulse at first sample", int'(ovrd_d), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule